// File: doc/BRIEF.md
# Multi-Format Stereo PCM Serial Receiver

This block takes stereo PCM from a three-wire serial link made of a bit clock, a word clock and a data line. It turns each left/right sample pair into two 24-bit words in the system clock domain. A 3-bit format select picks one of eight framings: four right-justified word lengths, left-justified, and I2S, in slave and master flavours. In the two master formats the block makes the bit clock and the word clock itself, by dividing the system clock. It also raises a drive-enable output so that the pads can turn those clocks around.

The bit clock and word clock are sampled by the system clock. The block never runs logic on the bit clock. All three serial lines pass through matched synchronizer chains, so data and word-clock samples stay aligned with the detected bit-clock rising edge. A completed pair is shown on the outputs with a one-cycle strobe. The pair stays there until the next one arrives. The format select is expected to change only while reset is held.

Top module: `pcm_rx_port`

## Requirements
- R1: Format codes 6 (left-justified master) and 7 (I2S master) raise `clk_drive_en` and drive `bck_out`/`wck_out`. Codes 0 to 5 keep `clk_drive_en`, `bck_out` and `wck_out` low, and the block follows `bck_in`/`wck_in`.
- R2: In master formats the bit clock period is 2*DIV_HALF system clocks. The word clock spans 64 bit clocks, is high for exactly 32 of them, and changes only while the bit clock is low.
- R3: In the left-justified formats (codes 4 and 6), word clock high marks the left channel. The MSB of a 24-bit word is the first bit sampled after a word-clock transition, and bits after the 24th are ignored.
- R4: In the I2S formats (codes 5 and 7), word clock low marks the left channel. The MSB is the second bit after a word-clock transition. The first bit and the bits after the 25th are ignored.
- R5: Codes 0, 1, 2 and 3 are right-justified with 16, 18, 20 and 24 bits, and word clock high is left. The word is the last N bits before the next word-clock transition. It is output left-aligned in 24 bits with the unused low bits zero.
- R6: In slave formats every per-channel bit count from the word length (I2S: 25) up to 64 is accepted, and data bits outside the word have no effect on the output.
- R7: `pair_valid` is a single-cycle pulse per completed left/right pair. `left_q`/`right_q` change only in the cycle `pair_valid` is high.
- R8: While reset is asserted, `pair_valid`, `left_q`, `right_q`, `bck_out` and `wck_out` are zero.
- R9: After reset no pair is reported until a full left word and a full right word that follows it have been captured. The partial frame seen at start-up is dropped, and each later frame yields exactly one pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Serial format code 0..7 |
| bck_in | input | 1 | Bit clock from the link (slave formats) |
| wck_in | input | 1 | Word clock from the link (slave formats) |
| sdata_in | input | 1 | Serial data, MSB first, changes after bit-clock falls |
| bck_out | output | 1 | Generated bit clock (master formats) |
| wck_out | output | 1 | Generated word clock (master formats) |
| clk_drive_en | output | 1 | High when the block drives the link clocks |
| left_q | output | 24 | Left sample of the last completed pair |
| right_q | output | 24 | Right sample of the last completed pair |
| pair_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
A bit counter that slips by one position shows up as a one-bit shift or a bad top bit in the very next captured word. That happens within one word-clock half period. A wrong channel-polarity or boundary flag swaps the left and right outputs, or drops a pair, and the following frame's pair exposes it. A fault in the master clock divider shows up on `bck_out` within a single bit period, and on the word-clock duty within one frame. Random per-channel bit counts and random filler bits outside the word catch offset errors that fixed framing would hide.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    // code 6 and 7 are the master variants
    function automatic logic fmt_is_master(input logic [2:0] f);
        return f[2] & f[1];
    endfunction

    // codes 5 and 7 use the one-bit delayed I2S framing
    function automatic logic fmt_is_i2s(input logic [2:0] f);
        return f[2] & f[0];
    endfunction

    // codes 0..3 are right-justified
    function automatic logic fmt_is_rj(input logic [2:0] f);
        return ~f[2];
    endfunction

    function automatic int unsigned rj_len(input logic [2:0] f);
        case (f[1:0])
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

    // word clock level that marks the left channel
    function automatic logic left_level(input logic [2:0] f);
        return ~fmt_is_i2s(f);
    endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_a,
    input  logic wck_a,
    input  logic sd_a,
    output logic bck_s,
    output logic wck_s,
    output logic sd_s,
    output logic bit_rise
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            bck_last_q;

    assign raw = {sd_a, wck_a, bck_a};

    // matched chains keep data and word clock aligned with the bit clock
    for (genvar g = 0; g < NSIG; g++) begin : g_chain
        logic [STAGES-1:0] stg_q;
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= {stg_q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = stg_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bck_last_q <= 1'b0;
        else        bck_last_q <= synced[0];
    end

    assign bck_s    = synced[0];
    assign wck_s    = synced[1];
    assign sd_s     = synced[2];
    assign bit_rise = synced[0] & ~bck_last_q;

endmodule

// File: rtl/pcm_rx_clkgen.sv
module pcm_rx_clkgen
    import pcm_rx_pkg::*;
#(
    parameter int DIV_HALF   = 4,
    parameter int FRAME_BITS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] fmt,
    output logic       bck_o,
    output logic       wck_o
);
    localparam int DW   = $clog2(DIV_HALF + 1);
    localparam int BN_W = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [DW-1:0]   div;
        logic            bck;
        logic            wck;
        logic [BN_W-1:0] bitn;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d = q;
        if (!en) begin
            d.div  = '0;
            d.bck  = 1'b0;
            d.bitn = '0;
        end else if (q.div == DW'(DIV_HALF - 1)) begin
            d.div = '0;
            d.bck = ~q.bck;
            if (q.bck) d.bitn = q.bitn + 1'b1;   // advance on the falling edge
        end else begin
            d.div = q.div + 1'b1;
        end
        // first half of the frame carries the left channel
        if (!en)                   d.wck = 1'b0;
        else if (d.bitn[BN_W-1])   d.wck = ~left_level(fmt);
        else                       d.wck = left_level(fmt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bck_o = q.bck;
    assign wck_o = q.wck;

    assert_wck_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wck_o != $past(wck_o)) |-> !bck_o);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bck_o);

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
    import pcm_rx_pkg::*;
#(
    parameter int W     = 24,
    parameter int CNT_W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   fmt,
    input  logic         bit_rise,
    input  logic         wck_s,
    input  logic         sd_s,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o,
    output logic         valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LJ_IDX  = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] I2S_IDX = CNT_W'(W);

    typedef struct packed {
        logic             started;
        logic             locked;
        logic             prev_wck;
        logic             have_left;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sr;
        logic [W-1:0]     lhold;
        logic [W-1:0]     left;
        logic [W-1:0]     right;
    } rx_t;

    rx_t q, d;

    logic [W-1:0] sr_n;
    logic [W-1:0] word;
    logic         boundary;
    logic         emit;
    logic         chan_left;
    logic         lvl;

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        sr_n      = q.sr;
        word      = '0;
        boundary  = 1'b0;
        emit      = 1'b0;
        chan_left = 1'b0;
        lvl       = left_level(fmt);
        if (bit_rise) begin
            sr_n       = {q.sr[W-2:0], sd_s};
            d.sr       = sr_n;
            boundary   = q.started && (wck_s != q.prev_wck);
            d.started  = 1'b1;
            d.prev_wck = wck_s;
            if (boundary) begin
                d.cnt    = '0;
                d.locked = 1'b1;
                // right-justified word ends just before the transition
                if (fmt_is_rj(fmt) && q.locked) begin
                    word      = q.sr << (W - rj_len(fmt));
                    chan_left = (q.prev_wck == lvl);
                    emit      = 1'b1;
                end
            end else if (q.cnt != CNT_MAX) begin
                d.cnt = q.cnt + 1'b1;
            end
            if (!fmt_is_rj(fmt) && d.locked &&
                d.cnt == (fmt_is_i2s(fmt) ? I2S_IDX : LJ_IDX)) begin
                word      = sr_n;
                chan_left = (wck_s == lvl);
                emit      = 1'b1;
            end
        end
        if (emit) begin
            if (chan_left) begin
                d.lhold     = word;
                d.have_left = 1'b1;
            end else if (q.have_left) begin
                d.left      = q.lhold;
                d.right     = word;
                d.valid     = 1'b1;
                d.have_left = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign left_o  = q.left;
    assign right_o = q.right;
    assign valid_o = q.valid;

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port
    import pcm_rx_pkg::*;
#(
    parameter int WORD_W        = 24,
    parameter int DIV_HALF      = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int MAX_FRAME_BCK = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fmt_sel,
    input  logic              bck_in,
    input  logic              wck_in,
    input  logic              sdata_in,
    output logic              bck_out,
    output logic              wck_out,
    output logic              clk_drive_en,
    output logic [WORD_W-1:0] left_q,
    output logic [WORD_W-1:0] right_q,
    output logic              pair_valid
);
    localparam int CNT_W      = $clog2(MAX_FRAME_BCK);
    localparam int FRAME_BITS = 64;

    logic master;
    logic gen_bck, gen_wck;
    logic bck_src, wck_src;
    logic bck_s, wck_s, sd_s, bit_rise;

    assign master = fmt_is_master(fmt_sel);

    pcm_rx_clkgen #(.DIV_HALF(DIV_HALF), .FRAME_BITS(FRAME_BITS)) u_gen (
        .clk(clk), .rst_n(rst_n), .en(master), .fmt(fmt_sel),
        .bck_o(gen_bck), .wck_o(gen_wck)
    );

    // the generated clocks take the same synchronizer path as the data
    assign bck_src = master ? gen_bck : bck_in;
    assign wck_src = master ? gen_wck : wck_in;

    pcm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .bck_a(bck_src), .wck_a(wck_src), .sd_a(sdata_in),
        .bck_s(bck_s), .wck_s(wck_s), .sd_s(sd_s), .bit_rise(bit_rise)
    );

    pcm_rx_deser #(.W(WORD_W), .CNT_W(CNT_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .fmt(fmt_sel),
        .bit_rise(bit_rise), .wck_s(wck_s), .sd_s(sd_s),
        .left_o(left_q), .right_o(right_q), .valid_o(pair_valid)
    );

    assign bck_out      = gen_bck;
    assign wck_out      = gen_wck;
    assign clk_drive_en = master;

    logic unused_bck_s;
    assign unused_bck_s = bck_s;

endmodule

// File: tb/pcm_rx_port_tb.sv
module pcm_rx_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SB         = 3 * CLK_PERIOD;   // slave half bit time
    localparam int DIV_HALF   = 4;
    localparam int NA         = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic        bck_in = 1'b0, wck_in = 1'b0, sdata_in = 1'b0;
    logic        bck_out, wck_out, clk_drive_en, pair_valid;
    logic [23:0] left_q, right_q;

    int checks = 0;
    int errors = 0;
    logic [23:0] expL [NA];
    logic [23:0] expR [NA];
    logic [2:0]  cur_fmt = 3'd0;
    bit          mon_on = 1'b0, mtx_on = 1'b0, prev_valid = 1'b0;
    int          rx_cnt = 0;
    logic [23:0] last_l = '0, last_r = '0;
    string       cur_tag = "R5";
    logic        m_lvl = 1'b1, m_lastw = 1'b1;
    int          m_pos = 0, m_frame = 0;

    pcm_rx_port #(.DIV_HALF(DIV_HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .bck_in(bck_in), .wck_in(wck_in), .sdata_in(sdata_in),
        .bck_out(bck_out), .wck_out(wck_out), .clk_drive_en(clk_drive_en),
        .left_q(left_q), .right_q(right_q), .pair_valid(pair_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int rj_n(input logic [2:0] f);
        if (f >= 3'd4) return 24;
        case (f[1:0])
            2'd0: return 16;
            2'd1: return 18;
            2'd2: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] exp_word(input logic [2:0] f, input logic [23:0] s);
        int n = rj_n(f);
        return s & ~((24'h1 << (24 - n)) - 24'h1);
    endfunction

    function automatic logic bit_at(input logic [2:0] f, input int pos, input int half,
                                    input logic [23:0] s, input logic nz);
        int n, j;
        if (f == 3'd4 || f == 3'd6) return (pos < 24) ? s[23-pos] : nz;
        if (f == 3'd5 || f == 3'd7) return (pos >= 1 && pos <= 24) ? s[24-pos] : nz;
        n = rj_n(f);
        j = half - 1 - pos;
        return (j < n) ? s[24-n+j] : nz;
    endfunction

    function automatic string fmt_tag(input logic [2:0] f);
        if (f < 3'd4) return "R5";
        if (f == 3'd4 || f == 3'd6) return "R3";
        return "R4";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill(input int nf);
        for (int i = 0; i <= nf + 2 && i < NA; i++) begin
            expL[i] = 24'($urandom);
            expR[i] = 24'($urandom);
        end
    endtask

    // pair monitor, sampled on the falling system clock edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (pair_valid) begin
                chk(!prev_valid, "R7 pulse width", 32'(prev_valid), 32'd0);
                if (rx_cnt + 1 < NA) begin
                    chk(left_q == exp_word(cur_fmt, expL[rx_cnt+1]), cur_tag,
                        32'(left_q), 32'(exp_word(cur_fmt, expL[rx_cnt+1])));
                    chk(right_q == exp_word(cur_fmt, expR[rx_cnt+1]), cur_tag,
                        32'(right_q), 32'(exp_word(cur_fmt, expR[rx_cnt+1])));
                end
                rx_cnt++;
            end else if (left_q != last_l || right_q != last_r) begin
                chk(1'b0, "R7 hold", 32'(left_q), 32'(last_l));
            end
            last_l = left_q;
            last_r = right_q;
        end
        prev_valid = pair_valid;
    end

    // transmitter that follows the block's own clocks in master formats
    always @(negedge bck_out) begin
        if (mtx_on) begin
            #1;
            if (wck_out != m_lastw) begin
                m_lastw = wck_out;
                m_pos   = 0;
                if (wck_out == m_lvl) m_frame++;
            end else begin
                m_pos++;
            end
            if (m_frame < NA)
                sdata_in = bit_at(cur_fmt, m_pos, 32,
                                  (wck_out == m_lvl) ? expL[m_frame] : expR[m_frame],
                                  1'($urandom));
        end
    end

    task automatic run_slave(input logic [2:0] f, input int half, input int nf, input string ctag);
        logic lvl;
        fmt_sel = f;
        cur_fmt = f;
        do_reset();
        fill(nf);
        lvl     = !(f == 3'd5 || f == 3'd7);
        cur_tag = fmt_tag(f);
        rx_cnt  = 0;
        last_l  = '0;
        last_r  = '0;
        mon_on  = 1'b1;
        for (int fr = 0; fr <= nf; fr++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int pos = 0; pos < half; pos++) begin
                    bck_in   = 1'b0;
                    wck_in   = (ch == 0) ? lvl : ~lvl;
                    sdata_in = bit_at(f, pos, half, (ch == 0) ? expL[fr] : expR[fr], 1'($urandom));
                    #SB;
                    bck_in = 1'b1;
                    #SB;
                end
            end
        end
        bck_in = 1'b0;
        #(SB * 4);
        mon_on = 1'b0;
        // R9: start-up frame dropped, every later frame reported once
        chk(rx_cnt == ((f < 3'd4) ? nf - 1 : nf), ctag, 32'(rx_cnt), 32'(nf));
        chk(bck_out == 1'b0 && wck_out == 1'b0 && clk_drive_en == 1'b0, "R1 slave idle",
            {29'd0, bck_out, wck_out, clk_drive_en}, 32'd0);
    endtask

    task automatic run_master(input logic [2:0] f, input int nf);
        time t0, t1, ta, tb, tc;
        fmt_sel = f;
        cur_fmt = f;
        m_lvl   = !(f == 3'd7);
        m_lastw = m_lvl;
        m_pos   = 0;
        m_frame = 0;
        sdata_in = 1'b0;
        fill(nf);
        cur_tag = fmt_tag(f);
        rx_cnt  = 0;
        last_l  = '0;
        last_r  = '0;
        do_reset();
        mtx_on = 1'b1;
        mon_on = 1'b1;
        chk(clk_drive_en == 1'b1, "R1 master enable", 32'(clk_drive_en), 32'd1);
        @(posedge bck_out); t0 = $time;
        @(posedge bck_out); t1 = $time;
        chk((t1 - t0) == 2 * DIV_HALF * CLK_PERIOD, "R2 bck period",
            32'(t1 - t0), 32'(2 * DIV_HALF * CLK_PERIOD));
        @(posedge wck_out); ta = $time;
        @(negedge wck_out); tb = $time;
        @(posedge wck_out); tc = $time;
        chk((tb - ta) == 32 * 2 * DIV_HALF * CLK_PERIOD, "R2 wck high time",
            32'(tb - ta), 32'(32 * 2 * DIV_HALF * CLK_PERIOD));
        chk((tc - ta) == 64 * 2 * DIV_HALF * CLK_PERIOD, "R2 wck period",
            32'(tc - ta), 32'(64 * 2 * DIV_HALF * CLK_PERIOD));
        wait (m_frame > nf);
        #(CLK_PERIOD * 4);
        mon_on = 1'b0;
        mtx_on = 1'b0;
        chk(rx_cnt == nf, "R9 master pair count", 32'(rx_cnt), 32'(nf));
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h00C0FFEE);
        // R8: reset state
        rst_n = 1'b0;
        fmt_sel = 3'd6;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pair_valid == 1'b0 && left_q == '0 && right_q == '0, "R8 outputs",
            32'(left_q), 32'd0);
        chk(bck_out == 1'b0 && wck_out == 1'b0, "R8 clocks", {30'd0, bck_out, wck_out}, 32'd0);
        // R1: drive enable per format code
        for (int f = 0; f < 8; f++) begin
            fmt_sel = 3'(f);
            #1;
            chk(clk_drive_en == (f >= 6), "R1 drive enable", 32'(clk_drive_en), 32'(f >= 6));
        end
        // directed: minimum lengths per format
        run_slave(3'd0, 16, 6, "R9 rj16 min");
        run_slave(3'd1, 18, 6, "R9 rj18 min");
        run_slave(3'd2, 20, 6, "R9 rj20 min");
        run_slave(3'd3, 24, 6, "R9 rj24 min");
        run_slave(3'd4, 24, 6, "R9 lj min");
        run_slave(3'd5, 25, 6, "R9 i2s min");
        run_slave(3'd0, 64, 4, "R6 rj16 max");
        run_slave(3'd5, 64, 4, "R6 i2s max");
        // random per-channel bit counts, R6
        for (int k = 0; k < 6; k++) begin
            int f, mn, h;
            f  = int'($urandom % 6);
            mn = (f == 5) ? 25 : rj_n(3'(f));
            h  = mn + int'($urandom % (64 - mn + 1));
            run_slave(3'(f), h, 5, "R6 random length");
        end
        run_master(3'd6, 6);
        run_master(3'd7, 6);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule